// File: doc/BRIEF.md
# Ethernet Transmit Pause and Stop Controller

This block sits between a transmit frame queue and an Ethernet MAC transmit engine and decides, cycle by cycle, whether the engine may begin its next frame. It lets software halt the transmitter gracefully: any frame already on the wire completes, and an interrupt pulse marks the point where the transmitter is quiet. It also lets software ask for one MAC Control PAUSE frame. Data frames stop at the next frame boundary, the PAUSE frame is sent, the request bit is cleared through a strobe, and data traffic resumes. A PAUSE frame may go out even while data frames are held by a graceful stop or by a pause received from the link partner.

A received pause (full duplex only) holds data frames for the advertised quanta times 512 bit times. A down-counter stepped by a bit-time tick measures this time, and the hold is reported on a status output. In half duplex, frames start only when carrier sense and collision are both low. In full duplex these inputs are ignored. An optional heartbeat check opens a window after each completed transmission and flags a sticky error if no collision-input pulse arrives within the window. The duplex and heartbeat configuration inputs are captured only while the MAC is disabled.

The core is a five-state machine:
- IDLE grants data frames.
- DATA is a data frame in flight.
- PSEND requests a PAUSE frame.
- PTX is a PAUSE frame in flight.
- HALT is the gracefully stopped state.

The transitions are:
- IDLE to PSEND on a pause request, raising the stop interrupt.
- IDLE to HALT on the stop bit, raising the stop interrupt.
- IDLE to DATA on a granted start.
- DATA to PSEND, HALT or IDLE on frame end or early collision. PSEND takes priority over HALT. PSEND and HALT raise the stop interrupt.
- PSEND to PTX on a granted start.
- PTX to HALT or IDLE on done, pulsing the request clear.
- PTX back to PSEND on an early collision.
- HALT to PSEND on a pause request.
- HALT to IDLE when the stop bit clears.

Top module: `eth_tx_hold_ctrl`

## Requirements
- R1: When `stop_req` is high as a data frame ends with `tx_done`, `stop_irq` is high for exactly the following cycle and `data_go` stays low afterwards. `stop_irq` stays low while the frame is still in flight.
- R2: Setting `stop_req` while no frame is in flight blocks `data_go` in that same cycle and raises `stop_irq` for one cycle on the next clock.
- R3: Clearing `stop_req` while stopped re-enables `data_go` one clock later, provided a frame is waiting (`frm_avail`=1).
- R4: An `early_col` pulse during a data frame with `stop_req` set ends the attempt, raises `stop_irq` and keeps `data_go` low. After `stop_req` clears, `data_go` returns so the same queued frame is retried. Without `stop_req`, `data_go` returns on the next clock.
- R5: A `pause_req` seen during a data frame holds data frames once that frame ends. The end of the frame raises `stop_irq` and drives `pause_send` high. `pause_req_clr` is high in the cycle the PAUSE frame's `tx_done` is given, and `data_go` resumes on the next clock.
- R6: `pause_send` can be asserted while data frames are held, either by `stop_req` or by `rx_paused`. After that PAUSE frame, the block returns to the stopped state if `stop_req` is still set. `data_go` is never high while `rx_paused` is high.
- R7: In full duplex, `rx_pause_vld` loads a hold of `rx_quanta`×512 `bit_tick`s. `rx_paused` is high for exactly that many cycles when `bit_tick` is constantly high. A new pulse reloads the count, and a quanta of 0 clears `rx_paused` on the next clock.
- R8: With full duplex captured, `data_go` ignores `crs` and `col`. In half duplex, `crs`=1 or `col`=1 forces `data_go` and `pause_send` low.
- R9: With the heartbeat enabled, `hb_err` rises HB_WIN `bit_tick`s after a `tx_done` if `col` stayed low in that window. A `col` pulse inside the window prevents the error. `hb_err` stays set until a `hb_err_clr` pulse.
- R10: After reset every output is 0. `cfg_full_dup` and `cfg_hb_en` are captured only while `mac_en`=0, and changes while `mac_en`=1 have no effect.
- R11: `data_go` and `pause_send` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mac_en | input | 1 | MAC enabled; while low the configuration inputs are captured |
| cfg_full_dup | input | 1 | Full-duplex mode select |
| cfg_hb_en | input | 1 | Heartbeat check enable |
| stop_req | input | 1 | Graceful stop control bit |
| pause_req | input | 1 | Request to transmit one PAUSE frame |
| frm_avail | input | 1 | A data frame is waiting in the queue |
| tx_start | input | 1 | Engine started the granted frame (strobe) |
| tx_done | input | 1 | Engine finished the current frame (strobe) |
| early_col | input | 1 | Early collision ended the current attempt (strobe) |
| crs | input | 1 | Carrier sense from the PHY |
| col | input | 1 | Collision from the PHY |
| bit_tick | input | 1 | One pulse per bit time |
| rx_pause_vld | input | 1 | A pause frame was received (strobe) |
| rx_quanta | input | QUANTA_W | Pause quanta carried by the received frame |
| hb_err_clr | input | 1 | Write-one-to-clear pulse for the heartbeat error |
| data_go | output | 1 | The engine may start a data frame |
| pause_send | output | 1 | The engine should start a PAUSE frame |
| stop_irq | output | 1 | One-cycle graceful-stop interrupt |
| pause_req_clr | output | 1 | Clears the pause request bit |
| rx_paused | output | 1 | A received pause is in force |
| hb_err | output | 1 | Sticky heartbeat error |

## Verification
Graceful stop is applied in three ways: mid-frame, while idle, and combined with an early collision. This separates "stop at the frame boundary" from "stop at once" and from "stop and retry". PAUSE frame requests are issued from three conditions: free running, gracefully stopped, and held by a received pause. These show that the PAUSE path bypasses both data holds and returns to the right state. Received pauses cover plain duration, reload and zero quanta. Heartbeat runs cover a window that expires silently and one that sees a collision. Carrier sense and collision are toggled under both duplex settings, including a duplex change attempted while the MAC is enabled.

// File: rtl/eth_txh_pkg.sv
package eth_txh_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DATA,
        ST_PSEND,
        ST_PTX,
        ST_HALT
    } txh_state_e;
endpackage

// File: rtl/eth_txh_fsm.sv
module eth_txh_fsm
    import eth_txh_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic stop_req,
    input  logic pause_req,
    input  logic frm_avail,
    input  logic tx_start,
    input  logic tx_done,
    input  logic early_col,
    input  logic medium_ok,
    input  logic rx_hold,
    output logic data_go,
    output logic pause_send,
    output logic stop_irq,
    output logic pause_req_clr
);
    txh_state_e state, nxt;
    logic       irq_nxt;

    // state register and registered interrupt
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            stop_irq <= 1'b0;
        end else begin
            state    <= nxt;
            stop_irq <= irq_nxt;
        end
    end

    // next state and outputs
    always_comb begin
        nxt           = state;
        irq_nxt       = 1'b0;
        data_go       = 1'b0;
        pause_send    = 1'b0;
        pause_req_clr = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (pause_req) begin
                    nxt     = ST_PSEND;
                    irq_nxt = 1'b1;
                end else if (stop_req) begin
                    nxt     = ST_HALT;
                    irq_nxt = 1'b1;
                end else begin
                    data_go = frm_avail && medium_ok && !rx_hold;
                    if (data_go && tx_start) nxt = ST_DATA;
                end
            end
            ST_DATA: begin
                if (tx_done || early_col) begin
                    if (pause_req) begin
                        nxt     = ST_PSEND;
                        irq_nxt = 1'b1;
                    end else if (stop_req) begin
                        nxt     = ST_HALT;
                        irq_nxt = 1'b1;
                    end else begin
                        nxt = ST_IDLE;
                    end
                end
            end
            ST_PSEND: begin
                pause_send = medium_ok;
                if (pause_send && tx_start) nxt = ST_PTX;
            end
            ST_PTX: begin
                if (tx_done) begin
                    pause_req_clr = 1'b1;
                    nxt = stop_req ? ST_HALT : ST_IDLE;
                end else if (early_col) begin
                    nxt = ST_PSEND;
                end
            end
            ST_HALT: begin
                if (pause_req)      nxt = ST_PSEND;
                else if (!stop_req) nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // R1: stop at frame boundary
    p_boundary_stop_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA && tx_done && stop_req && !pause_req) |=> (stop_irq && !data_go));
    // R2: stop while idle
    p_idle_stop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && stop_req && !pause_req) |=> stop_irq);
    // R4: collision while stopping lands in HALT
    p_col_halt_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA && early_col && !tx_done && stop_req && !pause_req) |=> (state == ST_HALT));
    // R5: request clear only with a finishing frame
    p_clr_with_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pause_req_clr |-> tx_done);
    // R11: grants are exclusive
    p_grant_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(data_go && pause_send));
endmodule

// File: rtl/eth_txh_rxpause.sv
module eth_txh_rxpause #(
    parameter int QUANTA_W   = 16,
    parameter int SLOT_SHIFT = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic                load,
    input  logic [QUANTA_W-1:0] quanta,
    input  logic                tick,
    output logic                paused
);
    localparam int CW = QUANTA_W + SLOT_SHIFT;
    logic [CW-1:0] remain;

    always_ff @(posedge clk) begin
        if (!rst_n)
            remain <= '0;
        else if (load && enable)
            remain <= CW'(quanta) << SLOT_SHIFT;
        else if (tick && remain != '0)
            remain <= remain - CW'(1);
    end

    assign paused = (remain != '0);

    // R7: nonzero quanta starts a hold, zero ends it
    p_load_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (load && enable && quanta != '0) |=> paused);
    p_zero_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (load && enable && quanta == '0) |=> !paused);
endmodule

// File: rtl/eth_txh_hbeat.sv
module eth_txh_hbeat #(
    parameter int HB_WIN = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic tx_end,
    input  logic col,
    input  logic tick,
    input  logic clr,
    output logic err
);
    localparam int WW = $clog2(HB_WIN + 1);
    logic [WW-1:0] win;
    logic          expire;

    assign expire = (win == WW'(1)) && tick && !col && !(tx_end && enable);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win <= '0;
        end else if (tx_end && enable) begin
            win <= WW'(HB_WIN);
        end else if (win != '0) begin
            if (col)       win <= '0;
            else if (tick) win <= win - WW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      err <= 1'b0;
        else if (expire) err <= 1'b1;
        else if (clr)    err <= 1'b0;
    end

    // R9: error is sticky until cleared
    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !clr) |=> err);
    // R9: collision inside the window never raises the error
    p_col_no_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!err && col && !tx_end) |=> !err);
endmodule

// File: rtl/eth_tx_hold_ctrl.sv
module eth_tx_hold_ctrl #(
    parameter int QUANTA_W   = 16,
    parameter int SLOT_SHIFT = 9,
    parameter int HB_WIN     = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                mac_en,
    input  logic                cfg_full_dup,
    input  logic                cfg_hb_en,
    input  logic                stop_req,
    input  logic                pause_req,
    input  logic                frm_avail,
    input  logic                tx_start,
    input  logic                tx_done,
    input  logic                early_col,
    input  logic                crs,
    input  logic                col,
    input  logic                bit_tick,
    input  logic                rx_pause_vld,
    input  logic [QUANTA_W-1:0] rx_quanta,
    input  logic                hb_err_clr,
    output logic                data_go,
    output logic                pause_send,
    output logic                stop_irq,
    output logic                pause_req_clr,
    output logic                rx_paused,
    output logic                hb_err
);
    logic fdx_q, hb_q, medium_ok;

    // configuration captured only while the MAC is disabled
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fdx_q <= 1'b0;
            hb_q  <= 1'b0;
        end else if (!mac_en) begin
            fdx_q <= cfg_full_dup;
            hb_q  <= cfg_hb_en;
        end
    end

    assign medium_ok = fdx_q || (!crs && !col);

    eth_txh_fsm i_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .stop_req      (stop_req),
        .pause_req     (pause_req),
        .frm_avail     (frm_avail),
        .tx_start      (tx_start),
        .tx_done       (tx_done),
        .early_col     (early_col),
        .medium_ok     (medium_ok),
        .rx_hold       (rx_paused),
        .data_go       (data_go),
        .pause_send    (pause_send),
        .stop_irq      (stop_irq),
        .pause_req_clr (pause_req_clr)
    );

    eth_txh_rxpause #(
        .QUANTA_W   (QUANTA_W),
        .SLOT_SHIFT (SLOT_SHIFT)
    ) i_rxpause (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (fdx_q),
        .load   (rx_pause_vld),
        .quanta (rx_quanta),
        .tick   (bit_tick),
        .paused (rx_paused)
    );

    eth_txh_hbeat #(
        .HB_WIN (HB_WIN)
    ) i_hbeat (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (hb_q),
        .tx_end (tx_done),
        .col    (col),
        .tick   (bit_tick),
        .clr    (hb_err_clr),
        .err    (hb_err)
    );

    // R10: configuration frozen while enabled
    p_cfg_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mac_en |=> ($stable(fdx_q) && $stable(hb_q)));
    // R8: half duplex respects the medium
    p_half_dup_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!fdx_q && (crs || col)) |-> (!data_go && !pause_send));
    // R6: received pause blocks data grants
    p_rx_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_paused |-> !data_go);
endmodule

// File: tb/test_eth_tx_hold_ctrl.sv
module test_eth_tx_hold_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int QW = 16;
    localparam int HBW = 64;

    logic clk = 1'b0;
    logic rst_n, mac_en, cfg_full_dup, cfg_hb_en, stop_req, pause_req;
    logic frm_avail, tx_start, tx_done, early_col, crs, col, bit_tick;
    logic rx_pause_vld, hb_err_clr;
    logic [QW-1:0] rx_quanta;
    logic data_go, pause_send, stop_irq, pause_req_clr, rx_paused, hb_err;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    eth_tx_hold_ctrl #(.QUANTA_W(QW), .HB_WIN(HBW)) i_eth_tx_hold_ctrl (
        .clk(clk), .rst_n(rst_n), .mac_en(mac_en), .cfg_full_dup(cfg_full_dup),
        .cfg_hb_en(cfg_hb_en), .stop_req(stop_req), .pause_req(pause_req),
        .frm_avail(frm_avail), .tx_start(tx_start), .tx_done(tx_done),
        .early_col(early_col), .crs(crs), .col(col), .bit_tick(bit_tick),
        .rx_pause_vld(rx_pause_vld), .rx_quanta(rx_quanta), .hb_err_clr(hb_err_clr),
        .data_go(data_go), .pause_send(pause_send), .stop_irq(stop_irq),
        .pause_req_clr(pause_req_clr), .rx_paused(rx_paused), .hb_err(hb_err)
    );

    // software register model: the pause request bit clears itself
    always @(posedge clk) if (pause_req_clr) pause_req <= 1'b0;

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic pulse_start();
        tx_start = 1'b1; step(1); tx_start = 1'b0; #1;
    endtask
    task automatic pulse_done();
        tx_done = 1'b1; step(1); tx_done = 1'b0; #1;
    endtask
    task automatic pulse_rx(input int q);
        rx_quanta = QW'(q); rx_pause_vld = 1'b1; step(1); rx_pause_vld = 1'b0; #1;
    endtask

    task automatic t_reset();
        rst_n = 0; mac_en = 0; cfg_full_dup = 0; cfg_hb_en = 0; stop_req = 0;
        pause_req = 0; frm_avail = 0; tx_start = 0; tx_done = 0; early_col = 0;
        crs = 0; col = 0; bit_tick = 1; rx_pause_vld = 0; rx_quanta = '0; hb_err_clr = 0;
        step(3);
        rst_n = 1; step(1);
        check("R10 reset data_go", data_go, 0);
        check("R10 reset pause_send", pause_send, 0);
        check("R10 reset stop_irq", stop_irq, 0);
        check("R10 reset clr", pause_req_clr, 0);
        check("R10 reset rx_paused", rx_paused, 0);
        check("R10 reset hb_err", hb_err, 0);
    endtask

    task automatic t_medium();
        frm_avail = 1; #1;
        check("R8 half idle medium go", data_go, 1);
        crs = 1; #1; check("R8 half crs blocks", data_go, 0);
        crs = 0; col = 1; #1; check("R8 half col blocks", data_go, 0);
        col = 0;
        cfg_full_dup = 1; step(1);
        mac_en = 1; crs = 1; #1;
        check("R8 full dup ignores crs", data_go, 1);
        col = 1; #1; check("R8 full dup ignores col", data_go, 1);
        col = 0; crs = 0;
        cfg_full_dup = 0; step(3); crs = 1; #1;
        check("R10 duplex frozen while enabled", data_go, 1);
        crs = 0; cfg_full_dup = 1; #1;
    endtask

    task automatic t_stop_midframe();
        pulse_start();
        check("R1 in flight no grant", data_go, 0);
        stop_req = 1; step(2);
        check("R1 no irq before end", stop_irq, 0);
        pulse_done();
        check("R1 irq at frame end", stop_irq, 1);
        check("R1 no grant when stopped", data_go, 0);
        step(1);
        check("R1 irq one cycle", stop_irq, 0);
        check("R1 still held", data_go, 0);
        stop_req = 0; step(1);
        check("R3 resume after clear", data_go, 1);
    endtask

    task automatic t_stop_idle();
        stop_req = 1; #1;
        check("R2 grant drops at once", data_go, 0);
        step(1);
        check("R2 immediate irq", stop_irq, 1);
        step(1);
        check("R2 irq one cycle", stop_irq, 0);
        stop_req = 0; step(1);
        check("R3 resume from idle stop", data_go, 1);
    endtask

    task automatic t_collision();
        pulse_start();
        stop_req = 1;
        early_col = 1; step(1); early_col = 0; #1;
        check("R4 irq after collision", stop_irq, 1);
        check("R4 halted", data_go, 0);
        step(3);
        check("R4 still halted", data_go, 0);
        stop_req = 0; step(1);
        check("R4 retry granted", data_go, 1);
        pulse_start();
        early_col = 1; step(1); early_col = 0; #1;
        check("R4 plain collision regrant", data_go, 1);
        check("R4 plain collision no irq", stop_irq, 0);
    endtask

    task automatic t_pause_tx();
        pulse_start();
        pause_req = 1; step(2);
        check("R5 no pause mid frame", pause_send, 0);
        pulse_done();
        check("R5 irq at frame end", stop_irq, 1);
        check("R5 pause requested", pause_send, 1);
        check("R5 data held", data_go, 0);
        pulse_start();
        check("R5 pause in flight", pause_send, 0);
        tx_done = 1; #1;
        check("R5 clear strobe", pause_req_clr, 1);
        step(1); tx_done = 0; #1;
        check("R5 request bit cleared", pause_req, 0);
        check("R5 data resumes", data_go, 1);
        check("R11 exclusive grants", pause_send, 0);
    endtask

    task automatic t_pause_while_stopped();
        stop_req = 1; step(1);
        pause_req = 1; step(1);
        check("R6 pause while stopped", pause_send, 1);
        check("R6 data held while stopped", data_go, 0);
        pulse_start(); pulse_done();
        check("R6 back to stop no data", data_go, 0);
        check("R6 back to stop no pause", pause_send, 0);
        stop_req = 0; step(1);
        check("R6 resume after stop", data_go, 1);
    endtask

    task automatic t_pause_while_rx();
        int n;
        pulse_rx(1);
        check("R7 rx pause active", rx_paused, 1);
        check("R6 rx pause holds data", data_go, 0);
        pause_req = 1; step(1);
        check("R6 pause frame under rx pause", pause_send, 1);
        pulse_start(); pulse_done();
        check("R6 still held by rx pause", data_go, 0);
        n = 0;
        while (rx_paused && n < 2000) begin n++; step(1); end
        check("R6 data after rx pause", data_go, 1);
    endtask

    task automatic t_rx_timing();
        int n;
        pulse_rx(2);
        n = 0;
        while (rx_paused && n < 5000) begin n++; step(1); end
        check("R7 duration 2 quanta", n, 1024);
        pulse_rx(1); step(99);
        pulse_rx(1);
        n = 0;
        while (rx_paused && n < 5000) begin n++; step(1); end
        check("R7 reload restarts", n, 512);
        pulse_rx(1); step(10);
        pulse_rx(0);
        check("R7 zero quanta ends", rx_paused, 0);
    endtask

    task automatic t_heartbeat();
        mac_en = 0; cfg_hb_en = 1; step(1); mac_en = 1;
        frm_avail = 1; #1;
        pulse_start(); pulse_done();
        step(60);
        check("R9 no error inside window", hb_err, 0);
        step(10);
        check("R9 error after window", hb_err, 1);
        step(20);
        check("R9 error sticky", hb_err, 1);
        hb_err_clr = 1; step(1); hb_err_clr = 0; #1;
        check("R9 error cleared", hb_err, 0);
        pulse_start(); pulse_done();
        step(10); col = 1; step(1); col = 0; step(100);
        check("R9 collision in window", hb_err, 0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_medium();
        t_stop_midframe();
        t_stop_idle();
        t_collision();
        t_pause_tx();
        t_pause_while_stopped();
        t_pause_while_rx();
        t_rx_timing();
        t_heartbeat();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule